// File: doc/BRIEF.md
# Divider Setting Loader for a Clock Synthesizer

This block keeps the divider settings of a clock synthesizer: a 9-bit feedback multiplier, a 3-bit output-divider code and a 2-bit diagnostic selector. Settings come in on one of two paths. The first is a set of parallel pins gated by an active-low strobe. The second is a three-wire serial port made of data, clock and load. Both paths write one shared holding register, and the path that wrote last decides its contents. The register drives the active multiplier and divider code. The selector bits steer a diagnostic output. A flag reports a multiplier outside the lock window.

All strobe and data inputs are asynchronous to the system clock. Each one passes through a two-flop synchronizer before edge detection. Clock frequencies, the PLL and the dividers themselves are outside this block. The feedback-divider output and the synthesizer output that feed the diagnostic multiplexer enter as plain inputs.

Top module: `divcfg_loader`

## Requirements
- R1: A high `rst` clears the held multiplier, divider code, selector and serial shift register at once. The strobe synchronizers restart with the parallel strobe seen low, so in the cycles after release the parallel pins are captured as a power-up default, with selector 00.
- R2: While `parLoadN` is low, the held value follows the pins: `activeM` = `parM`, `activeN` = {0, `parN`}, and the selector is cleared to 00.
- R3: On a rising edge of `parLoadN`, the pin values are captured. Later changes on the pins leave the outputs unchanged until `parLoadN` goes low again or a serial transfer happens.
- R4: `testOut` is 0 whenever the synchronized `parLoadN` is low, whatever the selector and the diagnostic inputs are.
- R5: A rising edge of `serClk` shifts `serData` into a 14-bit shift register, but only while `parLoadN` is high. Serial clocks received while `parLoadN` is low are ignored.
- R6: The serial word is sent most significant bit first as 14 bits: selector bit 1, selector bit 0, divider code bits 2..0, multiplier bits 8..0. The multiplier LSB is the last bit shifted in.
- R7: A rising edge of `serLoad` copies the shift register into the held value. The falling edge of `serLoad` changes nothing.
- R8: While `serLoad` is held high, each rising `serClk` edge copies the newly shifted word into the held value.
- R9: With `parLoadN` high, the selector sets `testOut`: 00 gives 0, 01 gives synchronized `serData`, 10 gives `divFbIn`, 11 gives `synthOutIn`.
- R10: `mOutOfRange` is 1 exactly when `activeM` is below `LockMinM` (default 10) or above `LockMaxM` (default 28).
- R11: A change on a strobe or a parallel pin reaches the held value on the third rising system clock edge after it is applied. The first two edges leave the outputs at their old value.
- R12: If a `serLoad` rising edge and a `serClk` rising edge are detected in the same cycle, the transfer carries the word that already includes the new bit. If a parallel strobe rising edge and a `serLoad` rising edge are detected in the same cycle, the parallel pins win.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Master reset, active high, asynchronous |
| parLoadN | input | 1 | Parallel load strobe, active low |
| parM | input | 9 | Parallel multiplier pins |
| parN | input | 2 | Parallel divider code pins |
| serClk | input | 1 | Serial shift clock |
| serData | input | 1 | Serial data |
| serLoad | input | 1 | Serial transfer/latch control |
| divFbIn | input | 1 | Feedback divider output for diagnostics |
| synthOutIn | input | 1 | Synthesizer output for diagnostics |
| activeM | output | 9 | Active feedback multiplier |
| activeN | output | 3 | Active output divider code |
| testOut | output | 1 | Diagnostic output |
| mOutOfRange | output | 1 | Multiplier outside lock window |

## Verification
Two pairs of events can collide in one synchronized cycle. The first pair is a serial load rising edge with a serial clock rising edge. The second is a parallel strobe rising edge with a serial load rising edge. The bench provokes each pair by changing both inputs at the same falling clock edge, so that both pass through identical synchronizers and are detected together. The result is judged against R12: the held value must equal the shifted word in the first case and the parallel pins in the second.

// File: rtl/divcfg_pkg.sv
package divcfg_pkg;
  localparam int M_W    = 9;
  localparam int N_W    = 3;
  localparam int PN_W   = 2;
  localparam int T_W    = 2;
  localparam int WORD_W = T_W + N_W + M_W;

  typedef enum logic [T_W-1:0] {
    TS_LOW   = 2'b00,
    TS_SDATA = 2'b01,
    TS_MDIV  = 2'b10,
    TS_FOUT  = 2'b11
  } testSel_e;

  typedef struct packed {
    testSel_e         test;
    logic [N_W-1:0]   nCode;
    logic [M_W-1:0]   mVal;
  } cfgWord_t;

  typedef struct packed {
    logic parMode;
    logic loadPar;
    logic shiftEn;
    logic xferSer;
  } ctrlStrb_t;
endpackage

// File: rtl/divcfg_sync.sv
module divcfg_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] chain [STAGES];

  genvar gi;
  generate
    for (gi = 0; gi < STAGES; gi++) begin : g_stage
      if (gi == 0) begin : g_first
        always_ff @(posedge clk or posedge rst) begin
          if (rst) chain[gi] <= '0;
          else     chain[gi] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk or posedge rst) begin
          if (rst) chain[gi] <= '0;
          else     chain[gi] <= chain[gi-1];
        end
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/divcfg_ctrl.sv
module divcfg_ctrl
  import divcfg_pkg::*;
#(
  parameter int SyncStages = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             parLoadN,
  input  logic [M_W-1:0]   parM,
  input  logic [PN_W-1:0]  parN,
  input  logic             serClk,
  input  logic             serData,
  input  logic             serLoad,
  output logic [M_W-1:0]   parMSync,
  output logic [PN_W-1:0]  parNSync,
  output logic             serDataSync,
  output ctrlStrb_t        strb
);
  localparam int CTL_W = 3;
  localparam int DAT_W = 1 + M_W + PN_W;

  logic [CTL_W-1:0] ctlRaw, ctlSync;
  logic [DAT_W-1:0] datRaw, datSync;
  logic pLoadS, sClkS, sLoadS;
  logic pLoadPrev, sClkPrev, sLoadPrev;
  logic pRise, sClkRise, sLoadRise;

  assign ctlRaw = {parLoadN, serClk, serLoad};
  assign datRaw = {serData, parM, parN};

  divcfg_sync #(.W(CTL_W), .STAGES(SyncStages)) ctlSync_i (
    .clk(clk), .rst(rst), .d(ctlRaw), .q(ctlSync)
  );
  divcfg_sync #(.W(DAT_W), .STAGES(SyncStages)) datSync_i (
    .clk(clk), .rst(rst), .d(datRaw), .q(datSync)
  );

  assign {pLoadS, sClkS, sLoadS}          = ctlSync;
  assign {serDataSync, parMSync, parNSync} = datSync;

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      pLoadPrev <= 1'b0;
      sClkPrev  <= 1'b0;
      sLoadPrev <= 1'b0;
    end else begin
      pLoadPrev <= pLoadS;
      sClkPrev  <= sClkS;
      sLoadPrev <= sLoadS;
    end
  end

  assign pRise     = pLoadS & ~pLoadPrev;
  assign sClkRise  = sClkS & ~sClkPrev;
  assign sLoadRise = sLoadS & ~sLoadPrev;

  always_comb begin
    strb.parMode = ~pLoadS;
    strb.loadPar = ~pLoadS | pRise;
    strb.shiftEn = pLoadS & sClkRise;
    strb.xferSer = pLoadS & (sLoadRise | (sLoadS & sClkRise));
  end
endmodule

// File: rtl/divcfg_dp.sv
module divcfg_dp
  import divcfg_pkg::*;
#(
  parameter int LockMinM = 10,
  parameter int LockMaxM = 28
) (
  input  logic             clk,
  input  logic             rst,
  input  ctrlStrb_t        strb,
  input  logic [M_W-1:0]   parMSync,
  input  logic [PN_W-1:0]  parNSync,
  input  logic             serDataSync,
  input  logic             divFbIn,
  input  logic             synthOutIn,
  output logic [M_W-1:0]   activeM,
  output logic [N_W-1:0]   activeN,
  output logic             testOut,
  output logic             mOutOfRange
);
  localparam logic [M_W-1:0] M_LO = M_W'(LockMinM);
  localparam logic [M_W-1:0] M_HI = M_W'(LockMaxM);

  logic [WORD_W-1:0] shiftQ, shiftD;
  cfgWord_t holdQ, parWord;

  assign shiftD = {shiftQ[WORD_W-2:0], serDataSync};

  always_comb begin
    parWord.test  = TS_LOW;
    parWord.nCode = {{(N_W-PN_W){1'b0}}, parNSync};
    parWord.mVal  = parMSync;
  end

  always_ff @(posedge clk or posedge rst) begin
    if (rst) shiftQ <= '0;
    else if (strb.shiftEn) shiftQ <= shiftD;
  end

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      holdQ <= '0;
    end else if (strb.loadPar) begin
      holdQ <= parWord;
    end else if (strb.xferSer) begin
      holdQ <= cfgWord_t'(strb.shiftEn ? shiftD : shiftQ);
    end
  end

  always_comb begin
    if (strb.parMode) begin
      testOut = 1'b0;
    end else begin
      unique case (holdQ.test)
        TS_LOW:   testOut = 1'b0;
        TS_SDATA: testOut = serDataSync;
        TS_MDIV:  testOut = divFbIn;
        TS_FOUT:  testOut = synthOutIn;
        default:  testOut = 1'b0;
      endcase
    end
  end

  assign activeM     = holdQ.mVal;
  assign activeN     = holdQ.nCode;
  assign mOutOfRange = (holdQ.mVal < M_LO) || (holdQ.mVal > M_HI);
endmodule

// File: rtl/divcfg_loader.sv
module divcfg_loader
  import divcfg_pkg::*;
#(
  parameter int SyncStages = 2,
  parameter int LockMinM   = 10,
  parameter int LockMaxM   = 28
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              parLoadN,
  input  logic [M_W-1:0]    parM,
  input  logic [PN_W-1:0]   parN,
  input  logic              serClk,
  input  logic              serData,
  input  logic              serLoad,
  input  logic              divFbIn,
  input  logic              synthOutIn,
  output logic [M_W-1:0]    activeM,
  output logic [N_W-1:0]    activeN,
  output logic              testOut,
  output logic              mOutOfRange
);
  ctrlStrb_t         strb;
  logic [M_W-1:0]    parMSync;
  logic [PN_W-1:0]   parNSync;
  logic              serDataSync;

  divcfg_ctrl #(.SyncStages(SyncStages)) ctrl_i (
    .clk(clk), .rst(rst), .parLoadN(parLoadN), .parM(parM), .parN(parN),
    .serClk(serClk), .serData(serData), .serLoad(serLoad),
    .parMSync(parMSync), .parNSync(parNSync), .serDataSync(serDataSync),
    .strb(strb)
  );

  divcfg_dp #(.LockMinM(LockMinM), .LockMaxM(LockMaxM)) dp_i (
    .clk(clk), .rst(rst), .strb(strb), .parMSync(parMSync),
    .parNSync(parNSync), .serDataSync(serDataSync), .divFbIn(divFbIn),
    .synthOutIn(synthOutIn), .activeM(activeM), .activeN(activeN),
    .testOut(testOut), .mOutOfRange(mOutOfRange)
  );
endmodule

// File: rtl/divcfg_loader_chk.sv
module divcfg_loader_chk (
  input logic       clk,
  input logic       rst,
  input logic       parLoadN,
  input logic [8:0] parM,
  input logic [1:0] parN,
  input logic       serClk,
  input logic       serLoad,
  input logic [8:0] activeM,
  input logic [2:0] activeN,
  input logic       testOut
);
  logic [2:0]  sinceRst;
  logic [2:0]  quietCnt;
  logic [13:0] inPrev;
  logic [13:0] inNow;

  assign inNow = {parLoadN, parM, parN, serClk, serLoad};

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      sinceRst <= '0;
      quietCnt <= '0;
      inPrev   <= '0;
    end else begin
      inPrev <= inNow;
      if (sinceRst != 3'd7) sinceRst <= sinceRst + 3'd1;
      if (inNow != inPrev) quietCnt <= '0;
      else if (quietCnt != 3'd7) quietCnt <= quietCnt + 3'd1;
    end
  end

  always @(posedge clk) begin
    if (rst) begin
      AST_RESET_CLEAR: assert (activeM == 9'd0 && activeN == 3'd0) // R1
        else $error("reset did not clear held value");
    end
  end

  AST_PAR_FOLLOW: assert property (@(posedge clk) disable iff (rst)
    (sinceRst >= 3'd5 && !$past(parLoadN, 3)) |->
      (activeM == $past(parM, 3) && activeN == {1'b0, $past(parN, 3)})); // R2

  AST_PAR_TEST_LOW: assert property (@(posedge clk) disable iff (rst)
    (sinceRst >= 3'd4 && !$past(parLoadN, 2)) |-> !testOut); // R4

  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (rst)
    (sinceRst >= 3'd5 && quietCnt >= 3'd3) |=>
      ($stable(activeM) && $stable(activeN))); // R3
endmodule

bind divcfg_loader divcfg_loader_chk chk_i (
  .clk(clk), .rst(rst), .parLoadN(parLoadN), .parM(parM), .parN(parN),
  .serClk(serClk), .serLoad(serLoad), .activeM(activeM),
  .activeN(activeN), .testOut(testOut)
);

// File: tb/divcfg_loader_tb_top.sv
`timescale 1ns/1ps
module divcfg_loader_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic parLoadN = 1'b1;
  logic [8:0] parM = 9'd20;
  logic [1:0] parN = 2'd1;
  logic serClk = 1'b0, serData = 1'b0, serLoad = 1'b0;
  logic divFbIn = 1'b0, synthOutIn = 1'b0;
  logic [8:0] activeM;
  logic [2:0] activeN;
  logic testOut, mOutOfRange;

  int vectors = 0;
  int fails = 0;
  bit done = 1'b0;

  logic [13:0] expSh = '0;
  logic [1:0]  expT = '0;
  logic [2:0]  expN = '0;
  logic [8:0]  expM = '0;

  always #2 clk = ~clk;

  divcfg_loader dut_i (
    .clk(clk), .rst(rst), .parLoadN(parLoadN), .parM(parM), .parN(parN),
    .serClk(serClk), .serData(serData), .serLoad(serLoad),
    .divFbIn(divFbIn), .synthOutIn(synthOutIn), .activeM(activeM),
    .activeN(activeN), .testOut(testOut), .mOutOfRange(mOutOfRange)
  );

  function automatic logic rangeExp(logic [8:0] m);
    return (m < 9'd10) || (m > 9'd28);
  endfunction

  function automatic logic testExp(logic [1:0] t, logic sd, logic fb, logic so);
    case (t)
      2'b00: return 1'b0;
      2'b01: return sd;
      2'b10: return fb;
      default: return so;
    endcase
  endfunction

  task automatic waitN(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic checkHold(string tag);
    vectors++;
    if (activeM !== expM || activeN !== expN) begin
      fails++;
      $display("FAIL %s: M/N actual=%0d/%0d expected=%0d/%0d", tag, activeM, activeN, expM, expN);
    end
    vectors++;
    if (mOutOfRange !== rangeExp(expM)) begin
      fails++;
      $display("FAIL R10 %s: flag actual=%0b expected=%0b", tag, mOutOfRange, rangeExp(expM));
    end
  endtask

  task automatic checkBit(string tag, logic act, logic exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual=%0b expected=%0b", tag, act, exp);
    end
  endtask

  task automatic shiftBit(logic b, string tag);
    serData = b;
    waitN(5);
    serClk = 1'b1;
    if (parLoadN) begin
      expSh = {expSh[12:0], b};
      if (serLoad) {expT, expN, expM} = expSh;
    end
    waitN(5);
    if (serLoad) checkHold(tag);
    serClk = 1'b0;
    waitN(5);
  endtask

  task automatic serialWord(logic [13:0] w);
    for (int i = 13; i >= 0; i--) shiftBit(w[i], "R5 shift");
    serLoad = 1'b1;
    waitN(5);
    {expT, expN, expM} = expSh;
    checkHold("R6 R7 serial transfer");
    serLoad = 1'b0;
    waitN(5);
    checkHold("R7 falling edge keeps value");
  endtask

  task automatic parallelLoad(logic [8:0] m, logic [1:0] n);
    parM = m; parN = n; parLoadN = 1'b0;
    divFbIn = 1'b1; synthOutIn = 1'b1; serData = 1'b1;
    waitN(5);
    expM = m; expN = {1'b0, n}; expT = 2'b00;
    checkHold("R2 transparent");
    checkBit("R4 test low in parallel", testOut, 1'b0);
    parLoadN = 1'b1;
    waitN(5);
    parM = ~m; parN = ~n;
    waitN(5);
    checkHold("R3 captured value held");
    checkBit("R2 selector cleared", testOut, 1'b0);
  endtask

  task automatic muxCheck();
    for (int k = 0; k < 4; k++) begin
      logic sd, fb, so;
      sd = 1'($urandom); fb = 1'($urandom); so = 1'($urandom);
      serData = sd; divFbIn = fb; synthOutIn = so;
      waitN(5);
      checkBit("R9 test mux", testOut, testExp(expT, sd, fb, so));
    end
  endtask

  initial begin
    void'($urandom(32'd4711));
    waitN(3);
    // R1 reset state
    checkHold("R1 reset");
    checkBit("R1 test low in reset", testOut, 1'b0);
    rst = 1'b0;
    waitN(6);
    expM = 9'd20; expN = 3'd1; expT = 2'b00;
    checkHold("R1 pins as power-up default");

    // R10 boundaries
    parallelLoad(9'd9, 2'd0);
    parallelLoad(9'd10, 2'd1);
    parallelLoad(9'd28, 2'd2);
    parallelLoad(9'd29, 2'd3);

    // R6 field order and R9 every selector code
    for (int t = 0; t < 4; t++) begin
      serialWord({2'(t), 3'd5, 9'd17});
      checkBit("R6 N field", activeN == 3'd5, 1'b1);
      muxCheck();
    end

    // R5 serial clocks ignored in parallel mode
    begin
      logic [13:0] keep;
      keep = expSh;
      parLoadN = 1'b0;
      waitN(5);
      expM = parM; expN = {1'b0, parN}; expT = 2'b00;
      for (int i = 0; i < 3; i++) shiftBit(1'b1, "R5");
      parLoadN = 1'b1;
      waitN(6);
      serLoad = 1'b1;
      waitN(5);
      {expT, expN, expM} = keep;
      checkHold("R5 shift register untouched in parallel mode");
      serLoad = 1'b0;
      waitN(5);
    end

    // R8 transparent serial mode
    serLoad = 1'b1;
    waitN(5);
    for (int i = 13; i >= 0; i--) shiftBit(1'($urandom), "R8 transparent update");
    serLoad = 1'b0;
    waitN(5);
    checkHold("R8 value kept after load falls");

    // R11 latency
    parLoadN = 1'b0;
    parM = 9'd12; parN = 2'd0;
    waitN(6);
    expM = 9'd12; expN = 3'd0; expT = 2'b00;
    parM = 9'd25; parN = 2'd3;
    waitN(2);
    checkHold("R11 unchanged after two edges");
    waitN(1);
    expM = 9'd25; expN = 3'd3;
    checkHold("R11 updated on third edge");
    parLoadN = 1'b1;
    waitN(6);

    // R12 serial load and serial clock in the same cycle
    serData = 1'b1;
    waitN(5);
    serClk = 1'b1; serLoad = 1'b1;
    expSh = {expSh[12:0], 1'b1};
    {expT, expN, expM} = expSh;
    waitN(5);
    checkHold("R12 load with same-cycle shift");
    serClk = 1'b0; serLoad = 1'b0;
    waitN(5);

    // R12 parallel strobe rise beats serial load
    parM = 9'd14; parN = 2'd2; parLoadN = 1'b0;
    waitN(6);
    parLoadN = 1'b1; serLoad = 1'b1;
    waitN(5);
    expM = 9'd14; expN = 3'd2; expT = 2'b00;
    checkHold("R12 parallel wins");
    serLoad = 1'b0;
    waitN(5);

    // random mix
    for (int it = 0; it < 30; it++) begin
      logic [8:0] m;
      m = ($urandom % 2) ? 9'(5 + $urandom % 30) : 9'($urandom);
      if ($urandom % 2) parallelLoad(m, 2'($urandom));
      else begin
        serialWord({2'($urandom), 3'($urandom), m});
        muxCheck();
      end
    end

    // R1 mid-run reset
    rst = 1'b1;
    waitN(1);
    expM = '0; expN = '0; expSh = '0;
    checkHold("R1 mid-run reset clears");
    parM = 9'd22; parN = 2'd3;
    rst = 1'b0;
    waitN(6);
    expM = 9'd22; expN = 3'd3; expT = 2'b00;
    checkHold("R1 default after reset");
    serLoad = 1'b1;
    waitN(5);
    expM = '0; expN = '0;
    checkHold("R1 shift register cleared");
    serLoad = 1'b0;
    waitN(5);

    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL R11 watchdog: actual=running expected=finished");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end
endmodule